// File: doc/BRIEF.md
# Task-Controlled Serial Byte Transmitter

This block sends bytes on an asynchronous serial line. Software-facing logic controls it with single-cycle command pulses: a begin pulse opens a transmit session, and an end pulse closes the session at once, even in the middle of a frame. During a session, a byte presented with a valid strobe is framed and shifted out. The block raises a one-cycle completion pulse when that byte has fully left the line, and the next byte may then be written.

A local divider sets the bit period to `CLKS_PER_BIT` clock cycles. An optional clear-to-send handshake can hold back new frames while the far end is not ready. A frame that is already on the line always runs to completion. A frame that is waiting starts by itself once the far end signals ready again. When the handshake is disabled, its input has no effect.

Top module: `uart_tx_seq`

## Requirements
- R1: After reset the serial line is high (idle) and the completion pulse is low.
- R2: A byte written while no session is open is discarded: the line stays high and no completion pulse occurs.
- R3: A frame is one low start bit, then the eight data bits least significant first, then one high stop bit. Each bit lasts `CLKS_PER_BIT` cycles. The start bit begins on the second rising edge after the cycle in which the write strobe is sampled.
- R4: The completion pulse is high for exactly one cycle. It rises `10*CLKS_PER_BIT` cycles after the start bit begins, which is after the stop bit has ended.
- R5: An end pulse aborts any frame in progress. On the next cycle the line is high, no completion pulse follows for the aborted byte, and later writes are discarded until a new begin pulse arrives.
- R6: With handshake enabled and `cts_ok` low, a written byte is held and not sent. When `cts_ok` returns high, the byte is sent and its completion pulse follows its frame.
- R7: If `cts_ok` falls while a frame is on the line, that frame still completes correctly.
- R8: With handshake disabled, `cts_ok` is ignored and frames are sent while it is low.
- R9: A write made while a byte is held or being sent is discarded. After the current frame completes, the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pulse | input | 1 | One-cycle command that opens a transmit session |
| stop_pulse | input | 1 | One-cycle command that closes the session and aborts any frame |
| wr_data | input | 8 | Byte to transmit |
| wr_valid | input | 1 | Write strobe for wr_data |
| done_evt | output | 1 | One-cycle pulse when a byte has been fully sent |
| flow_en | input | 1 | Enables the clear-to-send handshake |
| cts_ok | input | 1 | High when the far end accepts data |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The hardest case to reach from the ports is a handshake change that lands mid-frame, on a cycle the bench chooses. The frame monitor samples the line at bit centres and counts cycles from the start-bit edge. It can pull `cts_ok` low, or present a second write, at a fixed cycle count inside the frame it is watching. The stimulus therefore falls inside a known bit. The aborted-frame case is driven the same way: an end pulse is sent a fixed number of cycles after a write. The line and the completion output are then checked on the very next cycle and over a long quiet window.

// File: rtl/uart_tx_seq.sv
module uart_tx_seq #(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_pulse,
  input  logic                 stop_pulse,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 wr_valid,
  output logic                 done_evt,
  input  logic                 flow_en,
  input  logic                 cts_ok,
  output logic                 tx_line
);
  localparam int FRAME = DATA_BITS + 2;
  localparam int CW    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IW    = $clog2(FRAME + 1);

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_SEND} st_t;

  st_t                  st;
  logic                 active;
  logic [DATA_BITS-1:0] hold, shf;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic                 line_q, done_q;

  wire go_ok    = !flow_en || cts_ok;
  wire bit_end  = (cnt == CW'(CLKS_PER_BIT - 1));

  assign tx_line  = line_q;
  assign done_evt = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      active <= 1'b0;
      hold   <= '0;
      shf    <= '0;
      cnt    <= '0;
      idx    <= '0;
      line_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (stop_pulse) begin
        active <= 1'b0;
        st     <= S_IDLE;
        line_q <= 1'b1;
        cnt    <= '0;
        idx    <= '0;
      end else begin
        if (start_pulse) active <= 1'b1;
        case (st)
          S_IDLE: if (active && wr_valid) begin
            hold <= wr_data;
            st   <= S_HOLD;
          end
          S_HOLD: if (go_ok) begin
            st     <= S_SEND;
            shf    <= hold;
            line_q <= 1'b0;
            cnt    <= '0;
            idx    <= '0;
          end
          S_SEND: if (bit_end) begin
            cnt <= '0;
            if (idx == IW'(FRAME - 1)) begin
              st     <= S_IDLE;
              line_q <= 1'b1;
              done_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              if (idx == IW'(DATA_BITS)) begin
                line_q <= 1'b1;
              end else begin
                line_q <= shf[0];
                shf    <= shf >> 1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !done_evt);
  a_r4_done_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> tx_line);
  a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |=> (tx_line && !done_evt));
  a_r2_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> tx_line);
  a_r6_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !cts_ok && st != S_SEND) |=> tx_line);
endmodule

// File: tb/uart_tx_seq_bench.sv
module uart_tx_seq_bench;
  localparam int CPB = 4;
  localparam int FRAME_CYC = 10 * CPB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_pulse = 1'b0, stop_pulse = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic flow_en = 1'b0, cts_ok = 1'b1;
  logic done_evt, tx_line;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  uart_tx_seq #(.CLKS_PER_BIT(CPB), .DATA_BITS(8)) u_uart_tx_seq (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .wr_data(wr_data), .wr_valid(wr_valid), .done_evt(done_evt),
    .flow_en(flow_en), .cts_ok(cts_ok), .tx_line(tx_line));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_pulse = 1'b1;
    @(negedge clk); start_pulse = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // quiet window: line must stay high and no completion pulse
  task automatic quiet(input int n, input string req);
    int lows = 0, dones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!tx_line) lows++;
      if (done_evt) dones++;
    end
    chk(lows == 0, req, lows, 0);
    chk(dones == 0, req, dones, 0);
  endtask

  // waits for a start bit, then receives and checks one frame
  task automatic rx_frame(input logic [7:0] exp, input string req,
                          input bit inj_wr, input bit inj_cts_drop);
    int waited = 0, done_at = -1, dones = 0;
    logic [9:0] bits = '0;
    while (tx_line && waited < 40) begin @(negedge clk); waited++; end
    chk(!tx_line, {req, " start seen"}, tx_line, 0);
    for (int c = 0; c <= FRAME_CYC + 1; c++) begin
      if (c == 8 && inj_wr) begin wr_valid = 1'b1; wr_data = 8'h11; end
      if (c == 9 && inj_wr) wr_valid = 1'b0;
      if (c == 12 && inj_cts_drop) cts_ok = 1'b0;
      if (c % CPB == CPB / 2 && c / CPB < 10) bits[c / CPB] = tx_line;
      if (done_evt) begin dones++; if (done_at < 0) done_at = c; end
      if (c != FRAME_CYC + 1) @(negedge clk);
    end
    chk(bits[0] == 1'b0, {req, " start bit"}, bits[0], 0);
    chk(bits[8:1] == exp, {req, " data"}, bits[8:1], exp);
    chk(bits[9] == 1'b1, {req, " stop bit"}, bits[9], 1);
    chk(done_at == FRAME_CYC, {"R4 done timing ", req}, done_at, FRAME_CYC);
    chk(dones == 1, {"R4 done width ", req}, dones, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 line idle", tx_line, 1);
    chk(done_evt == 1'b0, "R1 done low", done_evt, 0);
  endtask

  task automatic t_closed_write();
    write_byte(8'h77);
    quiet(50, "R2 closed session write");
  endtask

  task automatic t_frames();
    pulse_start();
    write_byte(8'hA5); rx_frame(8'hA5, "R3 A5", 1'b0, 1'b0);
    write_byte(8'h3C); rx_frame(8'h3C, "R3 3C", 1'b0, 1'b0);
    write_byte(8'h00); rx_frame(8'h00, "R3 00", 1'b0, 1'b0);
    write_byte(8'hFF); rx_frame(8'hFF, "R3 FF", 1'b0, 1'b0);
  endtask

  task automatic t_busy_write();
    write_byte(8'h5A); rx_frame(8'h5A, "R9 busy", 1'b1, 1'b0);
    quiet(60, "R9 no second frame");
  endtask

  task automatic t_stop_abort();
    write_byte(8'h00);
    repeat (15) @(negedge clk);
    stop_pulse = 1'b1;
    @(negedge clk); stop_pulse = 1'b0;
    chk(tx_line == 1'b1, "R5 line high after stop", tx_line, 1);
    chk(done_evt == 1'b0, "R5 no done after stop", done_evt, 0);
    quiet(60, "R5 aborted frame quiet");
    write_byte(8'h00);
    quiet(50, "R5 write after stop discarded");
    pulse_start();
  endtask

  task automatic t_cts_hold();
    flow_en = 1'b1; cts_ok = 1'b0;
    write_byte(8'hC3);
    quiet(60, "R6 held by cts");
    @(negedge clk); cts_ok = 1'b1;
    rx_frame(8'hC3, "R6 resume", 1'b0, 1'b0);
  endtask

  task automatic t_cts_midframe();
    cts_ok = 1'b1;
    write_byte(8'h96); rx_frame(8'h96, "R7 cts drop", 1'b0, 1'b1);
    quiet(40, "R7 suspended after frame");
    cts_ok = 1'b1;
  endtask

  task automatic t_fc_off();
    flow_en = 1'b0; cts_ok = 1'b0;
    write_byte(8'h4B); rx_frame(8'h4B, "R8 cts ignored", 1'b0, 1'b0);
    cts_ok = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_closed_write();
    t_frames();
    t_busy_write();
    t_stop_abort();
    t_cts_hold();
    t_cts_midframe();
    t_fc_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule